// File: doc/BRIEF.md
# Sensor Configuration Bus Master (two-wire, single-byte register access)

This block is a two-wire serial bus master used to program the registers of a video sensor or similar peripheral. A host-side command port hands it a 7-bit device address, an 8-bit register index, a write byte and a direction flag. The block runs one complete bus transaction for that command. When the transaction ends it pulses `done`, reports whether the slave refused any byte, and on reads returns the byte fetched.

Writes send the device address with the write bit, then the register index, then the data byte, and finish with a STOP. Reads send the address and register index the same way. They then issue a repeated START with no intervening STOP, resend the address with the read bit, take one byte, answer it with a not-acknowledge, and finish with a STOP.

The bus clock comes from an internal divider. Each bit is split into four quarter phases. Three bus rates are available, and the fastest is selected out of reset. The block never samples SCL, so a slave holding the clock low has no effect on timing. It also has no arbitration. An active-low attention line from the sensor is synchronised and presented to the host as an active-high level.

Top module: `i2c_cfg_master`

## Requirements
- R1: After reset `scl_oe` and `sda_oe` are low, `cmd_ready` is high, `done`, `err` and `irq_active` are low, and the rate selection is code 00.
- R2: Rate codes are 00 for 800 kHz, 01 for 400 kHz and 10 for 100 kHz. A quarter phase lasts ceil(CLK_HZ / (4 x rate)) clock cycles, and every SCL period, from rising edge to rising edge, is exactly four quarters.
- R3: A `spd_load` with code 11 is ignored, and the previously selected rate stays in force.
- R4: A write produces exactly one START and one STOP around the bytes {address,0}, register and data, each sent MSB first with an acknowledge slot. `done` follows the accepting clock edge by exactly 116 quarters.
- R5: A read produces START, {address,0}, register, a repeated START with no STOP, {address,1}, one received byte answered with a not-acknowledge, and STOP. That is two STARTs and one STOP, with `done` 156 quarters after acceptance and `rd_data` holding the received byte.
- R6: If the slave leaves SDA high in the acknowledge slot of any transmitted byte, the block skips the remaining bytes and sends a STOP. `err` rises with `done`. An address refusal ends after 44 quarters and a register refusal after 80 quarters, and no data reaches the slave.
- R7: `sda_oe` changes only while `scl_oe` is asserted, except for the START and STOP edges. Each transaction therefore carries no START or STOP beyond those listed in R4 to R6.
- R8: `done` is high for exactly one cycle. `err` holds its value until the next command is accepted, and a successful command returns it to 0. `cmd_ready` is low during a transaction, and `cmd_valid` asserted then is ignored.
- R9: `irq_active` is the inverse of `irq_n` delayed by IRQ_SYNC clock edges (default 2).
- R10: The rate is captured when a command is accepted. A `spd_load` during a transaction does not change that transaction's timing and applies from the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spd_load | input | 1 | Strobe loading the rate code |
| spd_code | input | 2 | Rate code (00 fast, 01 mid, 10 slow, 11 ignored) |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is high |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_dev | input | 7 | Slave device address |
| cmd_reg | input | 8 | Register index |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ready | output | 1 | Idle and able to accept a command |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | A byte was refused in the last transaction |
| rd_data | output | 8 | Byte returned by the last successful read |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |
| irq_n | input | 1 | Active-low attention from the slave |
| irq_active | output | 1 | Synchronised attention level, active high |

## Verification
A wrong quarter count or a lost rate capture shows at once in the SCL edge spacing. It also moves the `done` pulse by whole quarters, so the transaction length is measured to the cycle. A sequencer that takes a wrong step appears on the wire within one symbol as an extra or missing START or STOP, or as a byte written to the wrong register of the modelled slave. A bad shift register shows on `rd_data` as soon as the read completes. A refusal that is not handled shows as early termination being absent, so `done` arrives late and `err` stays low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_TX,
      PH_RX,
      PH_STOP
   } ph_e;

   localparam logic [1:0] SPD_FAST = 2'd0;
   localparam logic [1:0] SPD_MID  = 2'd1;
   localparam logic [1:0] SPD_SLOW = 2'd2;
   localparam logic [1:0] SPD_RSVD = 2'd3;

   // cycles per quarter phase, rounded up so the bus never runs fast
   function automatic int unsigned qtr_cycles(input int unsigned clk_hz,
                                              input int unsigned bus_hz);
      return (clk_hz + 4 * bus_hz - 1) / (4 * bus_hz);
   endfunction

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick
   import i2cm_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned FAST_HZ = 800_000,
   parameter int unsigned MID_HZ  = 400_000,
   parameter int unsigned SLOW_HZ = 100_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] spd,
   output logic       tick
);
   localparam int unsigned Q_FAST = qtr_cycles(CLK_HZ, FAST_HZ);
   localparam int unsigned Q_MID  = qtr_cycles(CLK_HZ, MID_HZ);
   localparam int unsigned Q_SLOW = qtr_cycles(CLK_HZ, SLOW_HZ);
   localparam int          CW     = $clog2(Q_SLOW + 1);

   initial begin
      assert (Q_FAST >= 2)
         else $error("clock too slow for the fast bus rate");
      assert (Q_FAST <= Q_MID && Q_MID <= Q_SLOW)
         else $error("bus rates must be ordered fast > mid > slow");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      case (spd)
         SPD_FAST: lim = CW'(Q_FAST - 1);
         SPD_MID:  lim = CW'(Q_MID - 1);
         default:  lim = CW'(Q_SLOW - 1);
      endcase
   end

   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      assert (STAGES >= 1) else $error("synchroniser needs at least one stage");
   end

   generate
      if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{RST_VAL}};
            else        sr <= {sr[STAGES-2:0], din};
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_cfg_master.sv
module i2c_cfg_master
   import i2cm_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 100_000_000,
   parameter int unsigned FAST_HZ  = 800_000,
   parameter int unsigned MID_HZ   = 400_000,
   parameter int unsigned SLOW_HZ  = 100_000,
   parameter int          IRQ_SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spd_load,
   input  logic [1:0] spd_code,
   input  logic       cmd_valid,
   input  logic       cmd_read,
   input  logic [6:0] cmd_dev,
   input  logic [7:0] cmd_reg,
   input  logic [7:0] cmd_wdata,
   output logic       cmd_ready,
   output logic       done,
   output logic       err,
   output logic [7:0] rd_data,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_in,
   input  logic       irq_n,
   output logic       irq_active
);
   localparam int         BYTE_W   = 8;
   localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
   localparam logic [2:0] LAST_WR  = 3'd4;
   localparam logic [2:0] LAST_RD  = 3'd6;

   ph_e        ph;
   logic [1:0] qtr;
   logic [3:0] bitn;
   logic [7:0] shreg;
   logic [2:0] step;
   logic       rd_r;
   logic       ack_bit;
   logic       fail;
   logic [1:0] spd_r;
   logic [1:0] spd_cur;
   logic [6:0] dev_r;
   logic [7:0] reg_r;
   logic [7:0] wd_r;
   logic       tick;
   logic       irq_s;

   // ------------------------------------------------------------ helpers
   function automatic ph_e sym_of(input logic [2:0] s, input logic rd);
      ph_e r;
      if (s == 3'd0)      r = PH_START;
      else if (rd) begin
         case (s)
            3'd3:    r = PH_START;
            3'd5:    r = PH_RX;
            3'd6:    r = PH_STOP;
            default: r = PH_TX;
         endcase
      end
      else if (s == LAST_WR) r = PH_STOP;
      else                   r = PH_TX;
      return r;
   endfunction

   logic [2:0] nxt_step;
   ph_e        nxt_ph;
   logic [7:0] nxt_byte;

   always_comb begin
      nxt_step = step + 3'd1;
      nxt_ph   = sym_of(nxt_step, rd_r);
      case (nxt_step)
         3'd1:    nxt_byte = {dev_r, 1'b0};
         3'd2:    nxt_byte = reg_r;
         3'd3:    nxt_byte = wd_r;
         3'd4:    nxt_byte = {dev_r, 1'b1};
         default: nxt_byte = '0;
      endcase
   end

   // ------------------------------------------------------------ sub-blocks
   i2cm_qtick #(
      .CLK_HZ (CLK_HZ),
      .FAST_HZ(FAST_HZ),
      .MID_HZ (MID_HZ),
      .SLOW_HZ(SLOW_HZ)
   ) u_qtick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ph != PH_IDLE),
      .spd  (spd_cur),
      .tick (tick)
   );

   i2cm_sync #(
      .STAGES (IRQ_SYNC),
      .RST_VAL(1'b1)
   ) u_irq_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (irq_n),
      .dout (irq_s)
   );

   assign irq_active = ~irq_s;
   assign cmd_ready  = (ph == PH_IDLE);

   // ------------------------------------------------------------ sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         qtr     <= '0;
         bitn    <= '0;
         shreg   <= '0;
         step    <= '0;
         rd_r    <= 1'b0;
         ack_bit <= 1'b0;
         fail    <= 1'b0;
         spd_r   <= SPD_FAST;
         spd_cur <= SPD_FAST;
         dev_r   <= '0;
         reg_r   <= '0;
         wd_r    <= '0;
         scl_oe  <= 1'b0;
         sda_oe  <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         if (spd_load && spd_code != SPD_RSVD) spd_r <= spd_code;

         if (ph == PH_IDLE) begin
            if (cmd_valid) begin
               dev_r   <= cmd_dev;
               reg_r   <= cmd_reg;
               wd_r    <= cmd_wdata;
               rd_r    <= cmd_read;
               spd_cur <= spd_r;
               step    <= '0;
               bitn    <= '0;
               qtr     <= '0;
               fail    <= 1'b0;
               err     <= 1'b0;
               ph      <= PH_START;
               scl_oe  <= 1'b1;
            end
         end else if (tick) begin
            qtr <= qtr + 2'd1;
            case (qtr)
               2'd0: begin                       // entering quarter 1: SCL still low
                  case (ph)
                     PH_START: sda_oe <= 1'b0;
                     PH_STOP:  sda_oe <= 1'b1;
                     PH_TX:    sda_oe <= (bitn < ACK_SLOT) ? ~shreg[7] : 1'b0;
                     default:  sda_oe <= 1'b0;
                  endcase
               end
               2'd1: scl_oe <= 1'b0;              // entering quarter 2: SCL released
               2'd2: begin                       // entering quarter 3: sample, START/STOP edge
                  case (ph)
                     PH_START: sda_oe <= 1'b1;
                     PH_STOP:  sda_oe <= 1'b0;
                     PH_TX:    if (bitn == ACK_SLOT) ack_bit <= sda_in;
                     PH_RX:    if (bitn < ACK_SLOT) shreg <= {shreg[6:0], sda_in};
                     default:  ;
                  endcase
               end
               default: begin                    // end of the symbol or bit
                  scl_oe <= 1'b1;
                  if ((ph == PH_TX || ph == PH_RX) && bitn < ACK_SLOT) begin
                     bitn <= bitn + 4'd1;
                     if (ph == PH_TX) shreg <= {shreg[6:0], 1'b0};
                  end else if (ph == PH_STOP) begin
                     ph     <= PH_IDLE;
                     scl_oe <= 1'b0;
                     done   <= 1'b1;
                     err    <= fail;
                     step   <= '0;
                  end else if (ph == PH_TX && ack_bit) begin
                     fail <= 1'b1;
                     step <= rd_r ? LAST_RD : LAST_WR;
                     ph   <= PH_STOP;
                     bitn <= '0;
                  end else begin
                     if (ph == PH_RX) rd_data <= shreg;
                     step  <= nxt_step;
                     ph    <= nxt_ph;
                     shreg <= nxt_byte;
                     bitn  <= '0;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_cfg_master_chk.sv
module i2c_cfg_master_chk
   import i2cm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input ph_e        ph,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       done,
   input logic       err,
   input logic       cmd_ready,
   input logic [1:0] spd_cur
);
   // R7
   sda_while_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (scl_oe || ph == PH_START || ph == PH_STOP));

   // R8
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   // R6
   err_rise_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   // R1
   idle_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!scl_oe && !sda_oe));

   // R10
   rate_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && $past(ph) != PH_IDLE) |-> $stable(spd_cur));
endmodule

bind i2c_cfg_master i2c_cfg_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ph       (ph),
   .scl_oe   (scl_oe),
   .sda_oe   (sda_oe),
   .done     (done),
   .err      (err),
   .cmd_ready(cmd_ready),
   .spd_cur  (spd_cur)
);

// File: tb/sim_i2c_cfg_master.sv
`timescale 1ns/1ps
module sim_i2c_cfg_master;
   localparam int unsigned CLK_HZ  = 6_400_000;
   localparam int unsigned FAST_HZ = 800_000;
   localparam int unsigned MID_HZ  = 400_000;
   localparam int unsigned SLOW_HZ = 100_000;
   localparam logic [6:0]  SLV     = 7'h3C;
   localparam logic [7:0]  NACK_REG = 8'hEE;

   function automatic int qd(input int unsigned f);
      return int'((CLK_HZ + 4 * f - 1) / (4 * f));
   endfunction

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spd_load = 1'b0;
   logic [1:0] spd_code = 2'd0;
   logic       cmd_valid = 1'b0;
   logic       cmd_read = 1'b0;
   logic [6:0] cmd_dev = '0;
   logic [7:0] cmd_reg = '0;
   logic [7:0] cmd_wdata = '0;
   logic       cmd_ready, done, err, scl_oe, sda_oe, irq_active;
   logic [7:0] rd_data;
   logic       irq_n = 1'b1;
   logic       sl_drive = 1'b0;
   logic       sda_in;

   assign sda_in = !(sda_oe || sl_drive);

   always #5 clk = ~clk;

   i2c_cfg_master #(
      .CLK_HZ(CLK_HZ), .FAST_HZ(FAST_HZ), .MID_HZ(MID_HZ), .SLOW_HZ(SLOW_HZ), .IRQ_SYNC(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .spd_load(spd_load), .spd_code(spd_code),
      .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
      .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .done(done), .err(err),
      .rd_data(rd_data), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
      .irq_n(irq_n), .irq_active(irq_active)
   );

   int nchk = 0;
   int nfail = 0;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------------------------------------------------- slave model
   logic [7:0] mem [256];
   int   cyc = 0;
   int   txn_id = 0, seen_id = 0;
   int   n_start = 0, n_stop = 0, pmin = 0, pmax = 0, last_rise = 0;
   bit   have_rise = 0, active = 0, tx = 0, rw = 0, p_scl = 1, p_sda = 1;
   int   bitc = 0, byte_n = 0;
   logic [7:0] sh = '0, txb = '0, ptr = '0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      bit scl, sda;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
         sl_drive = 0; active = 0;
      end else begin
         if (seen_id != txn_id) begin
            seen_id = txn_id; n_start = 0; n_stop = 0;
            pmin = 1 << 30; pmax = 0; have_rise = 0;
         end
         scl = !scl_oe;
         sda = !(sda_oe || sl_drive);
         if (scl && p_scl && p_sda && !sda) begin
            n_start++; active = 1; bitc = 0; byte_n = 0; tx = 0; sl_drive = 0;
         end else if (scl && p_scl && !p_sda && sda) begin
            n_stop++; active = 0; sl_drive = 0;
         end else if (scl && !p_scl) begin
            if (have_rise) begin
               if (cyc - last_rise < pmin) pmin = cyc - last_rise;
               if (cyc - last_rise > pmax) pmax = cyc - last_rise;
            end
            last_rise = cyc; have_rise = 1;
            if (active) begin
               if (!tx && bitc < 8) sh = {sh[6:0], sda};
               bitc++;
            end
         end else if (!scl && p_scl && active) begin
            if (bitc == 8 && !tx) begin
               bit ack;
               if (byte_n == 0) begin
                  rw = sh[0]; ack = (sh[7:1] == SLV);
               end else if (byte_n == 1 && !rw) begin
                  ptr = sh; ack = (sh != NACK_REG);
               end else begin
                  mem[ptr] = sh; ptr++; ack = 1;
               end
               if (ack) sl_drive = 1;
               else begin sl_drive = 0; active = 0; end
            end else if (bitc == 8 && tx) begin
               sl_drive = 0;
            end else if (bitc == 9) begin
               sl_drive = 0;
               if (byte_n == 0 && rw) begin
                  tx = 1; txb = mem[ptr]; sl_drive = !txb[7];
               end else tx = 0;
               bitc = 0; byte_n++;
            end else if (tx && bitc >= 1 && bitc <= 7) begin
               sl_drive = !txb[7 - bitc];
            end
         end
         p_scl = scl;
         p_sda = !(sda_oe || sl_drive);
      end
   end

   // ---------------------------------------------------------- helpers
   task automatic run_cmd(input logic rd, input logic [6:0] dev, input logic [7:0] rg,
                          input logic [7:0] wd, output int n);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      txn_id++;
      cmd_read = rd; cmd_dev = dev; cmd_reg = rg; cmd_wdata = wd; cmd_valid = 1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 0;
      n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
      end while (!done && n < 50000);
   endtask

   task automatic set_speed(input logic [1:0] c);
      @(negedge clk);
      spd_load = 1; spd_code = c;
      @(negedge clk);
      spd_load = 0;
   endtask

   // ---------------------------------------------------------- watchdog
   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   // ---------------------------------------------------------- sequence
   initial begin
      int n;
      int qf, qm, qs;
      qf = qd(FAST_HZ); qm = qd(MID_HZ); qs = qd(SLOW_HZ);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 scl_oe", int'(scl_oe), 0);
      chk("R1 sda_oe", int'(sda_oe), 0);
      chk("R1 cmd_ready", int'(cmd_ready), 1);
      chk("R1 done", int'(done), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 irq_active", int'(irq_active), 0);
      rst_n = 1;

      // R1 R2 R4: default rate is fast
      run_cmd(0, SLV, 8'h10, 8'hA5, n);
      chk("R1 default rate period", pmax, 4 * qf);
      chk("R4 write length", n, 116 * qf);
      chk("R4 write data", int'(mem[8'h10]), 8'hA5);
      chk("R7 write starts", n_start, 1);
      chk("R7 write stops", n_stop, 1);
      @(negedge clk);
      chk("R8 done single cycle", int'(done), 0);

      // R2 R4 R5: sweep over the three rates
      for (int c = 0; c < 3; c++) begin
         int q;
         logic [7:0] d;
         q = (c == 0) ? qf : (c == 1) ? qm : qs;
         d = 8'h3C ^ 8'(c * 8'h55);
         set_speed(2'(c));
         run_cmd(0, SLV, 8'(8'h20 + c), d, n);
         chk("R2 period min", pmin, 4 * q);
         chk("R2 period max", pmax, 4 * q);
         chk("R4 write length", n, 116 * q);
         chk("R4 write data", int'(mem[8'h20 + c]), int'(d));
         run_cmd(1, SLV, 8'(8'h20 + c), 8'h00, n);
         chk("R5 read length", n, 156 * q);
         chk("R5 read data", int'(rd_data), int'(d));
         chk("R5 repeated start count", n_start, 2);
         chk("R5 single stop", n_stop, 1);
         chk("R8 err clear", int'(err), 0);
      end

      // R3: reserved code leaves mid rate in force
      set_speed(2'd1);
      set_speed(2'd3);
      run_cmd(0, SLV, 8'h30, 8'h5E, n);
      chk("R3 reserved code ignored", pmax, 4 * qm);
      chk("R3 length", n, 116 * qm);

      // R10: rate change during a transfer applies to the next one
      set_speed(2'd0);
      fork
         run_cmd(0, SLV, 8'h31, 8'h99, n);
         begin
            repeat (40) @(negedge clk);
            spd_load = 1; spd_code = 2'd2;
            @(negedge clk);
            spd_load = 0;
         end
      join
      chk("R10 current transfer unchanged", n, 116 * qf);
      run_cmd(0, SLV, 8'h32, 8'h66, n);
      chk("R10 next transfer slow", n, 116 * qs);
      chk("R10 slow period", pmax, 4 * qs);
      set_speed(2'd0);

      // near-exhaustive data sweep at the fast rate
      for (int i = 0; i < 16; i++) begin
         logic [7:0] rg, d;
         rg = 8'(i * 16 + 1);
         d  = 8'((i * 37 + 5) & 255);
         run_cmd(0, SLV, rg, d, n);
         chk("R4 sweep write", int'(mem[rg]), int'(d));
         run_cmd(1, SLV, rg, 8'h00, n);
         chk("R5 sweep read", int'(rd_data), int'(d));
      end

      // R6: address refused (write, then read)
      run_cmd(0, SLV ^ 7'h01, 8'h40, 8'h12, n);
      chk("R6 addr nack length", n, 44 * qf);
      chk("R6 addr nack err", int'(err), 1);
      chk("R6 addr nack stop", n_stop, 1);
      chk("R6 no write", int'(mem[8'h40]), int'(8'h40 ^ 8'h5A));
      @(negedge clk);
      chk("R8 err held", int'(err), 1);
      run_cmd(1, SLV ^ 7'h10, 8'h40, 8'h00, n);
      chk("R6 read addr nack length", n, 44 * qf);
      chk("R6 read addr nack err", int'(err), 1);

      // R6: register index refused
      run_cmd(0, SLV, NACK_REG, 8'h77, n);
      chk("R6 reg nack length", n, 80 * qf);
      chk("R6 reg nack err", int'(err), 1);
      chk("R6 reg not written", int'(mem[NACK_REG]), int'(NACK_REG ^ 8'h5A));

      // R8: success clears err, busy ignores cmd_valid
      fork
         run_cmd(0, SLV, 8'h41, 8'hC3, n);
         begin
            repeat (30) @(negedge clk);
            chk("R8 busy not ready", int'(cmd_ready), 0);
            cmd_valid = 1; cmd_read = 0; cmd_reg = 8'h77; cmd_wdata = 8'h11;
            repeat (10) @(negedge clk);
            cmd_valid = 0;
         end
      join
      chk("R8 err cleared", int'(err), 0);
      chk("R8 one transaction", n_start, 1);
      chk("R8 busy command ignored", int'(mem[8'h77]), int'(8'h77 ^ 8'h5A));
      chk("R8 first command done", int'(mem[8'h41]), 8'hC3);

      // R9: interrupt synchroniser latency
      @(negedge clk);
      irq_n = 0;
      @(negedge clk);
      chk("R9 irq after one edge", int'(irq_active), 0);
      @(negedge clk);
      chk("R9 irq after two edges", int'(irq_active), 1);
      irq_n = 1;
      @(negedge clk);
      chk("R9 release after one edge", int'(irq_active), 1);
      @(negedge clk);
      chk("R9 release after two edges", int'(irq_active), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule